// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers interrupt events for a script-driven I/O controller and presents them to software through read-to-clear status registers. There are two groups of events. DMA-class events post into one status register. Bus-class events post into a bank of status registers. Each status register has its own enable register, and a summary register reports what is pending. The block drives an interrupt request line. It also drives a halt line that stops the script engine.

Each status register is backed by a one-deep pending queue, so an event is never lost while an earlier word waits to be read. A read returns the posted word, and the queued word moves up at once to take its place. The top bit of the DMA status word is a live FIFO-empty indicator that no read clears. Software clears or drains the FIFOs through control registers that emit one-cycle strobes. An interrupt never touches the FIFOs.

Top module: `intr_stack_ctrl`

## Requirements
- R1: An event pulse on bit k of `dma_ev` or `bus_ev`, arriving while the matching status word is empty, is readable at bit k of that word from the clock edge that samples it. This holds whatever the enable bits are. DMA status is at address 0 with its events in bits 6..0. Bus status words are at addresses 2 and 3 and hold `bus_ev[7:0]` and `bus_ev[15:8]`.
- R2: A read of a status register returns the posted word. If nothing is queued and no event arrives in that cycle, the event bits read zero afterwards, and the matching pending bit in the summary register clears.
- R3: Events that arrive while a word is posted are ORed into a queued word. A read reloads the queued word into the status register at the same edge. If the queue is empty, a read instead loads the events of that same cycle.
- R4: Bit 7 of the DMA status word reads as `dma_fifo_empty AND bus_fifo_empty` on every read. A read does not clear it, and it never raises `irq` or `halt`.
- R5: Writing 1 to bit 2 of address 7 pulses `dma_fifo_clr`, and writing 1 to bit 3 of the same address pulses `dma_fifo_flush`. Writing 1 to bit 1 of address 8 pulses `bus_fifo_clr`. Each pulse is high for exactly the one cycle after the write edge. Interrupt events never pulse these outputs.
- R6: A bus status bit whose enable bit is clear stays recorded but does not drive `irq`. Enables are at address 4 (for address 2) and address 5 (for address 3).
- R7: Any posted DMA status event bit holds `halt` high, whatever the DMA enable register at address 1 contains.
- R8: A posted bus bit holds `halt` high when its enable bit is set, or when it belongs to the always-fatal set `BUS_FATAL` (default: bits 0 and 1 of address 2).
- R9: `irq` is the OR of every posted status bit whose enable bit is set, across the DMA and bus registers.
- R10: After reset all status, queue and enable registers are zero and every output is low. Enable registers read back what was written. Writes to status or summary addresses are ignored.
- R11: The summary register at address 6 reads {`irq`, `halt`, any bus pending, DMA pending} in bits 3..0, and a read of it clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_ev | input | 7 | DMA-class event pulses |
| bus_ev | input | 16 | Bus-class event pulses, two bytes |
| dma_fifo_empty | input | 1 | DMA FIFO empty status |
| bus_fifo_empty | input | 1 | Bus FIFO empty status |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read enable; the read clears at the clock edge |
| reg_rdata | output | 8 | Read data, valid in the cycle `reg_rd` is high |
| dma_fifo_clr | output | 1 | One-cycle DMA FIFO clear strobe |
| dma_fifo_flush | output | 1 | One-cycle DMA FIFO flush strobe |
| bus_fifo_clr | output | 1 | One-cycle bus FIFO clear strobe |
| irq | output | 1 | Interrupt request |
| halt | output | 1 | Halt request to the script engine |

## Verification
A queue that fails to reload shows up on the very next status read: it returns zero where the second event word was expected, and `halt` drops one cycle early. A posted word that is never cleared leaves `halt` high after the read, where the summary register should read zero. A mistake in classifying an event shows on `irq` or `halt` in the same cycle the event is posted. A wrong strobe source shows as a pulse, or a missing pulse, in the single cycle after a control write or an event.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
  // Control register strobe bit positions (software contract)
  localparam int DCTL_CLR_BIT   = 2;
  localparam int DCTL_FLUSH_BIT = 3;
  localparam int BCTL_CLR_BIT   = 1;

  // Summary register bit positions
  localparam int SUM_DMA  = 0;
  localparam int SUM_BUS  = 1;
  localparam int SUM_HALT = 2;
  localparam int SUM_IRQ  = 3;
  localparam int SUM_W    = 4;

  typedef struct packed {
    logic irq;
    logic halt;
    logic bus_pend;
    logic dma_pend;
  } summary_t;

  function automatic logic [SUM_W-1:0] pack_summary(input summary_t s);
    logic [SUM_W-1:0] w;
    w = '0;
    w[SUM_DMA]  = s.dma_pend;
    w[SUM_BUS]  = s.bus_pend;
    w[SUM_HALT] = s.halt;
    w[SUM_IRQ]  = s.irq;
    return w;
  endfunction
endpackage

// File: rtl/isc_stack.sv
`timescale 1ns/1ps
module isc_stack #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         rd_clr,
  output logic [W-1:0] posted
);
  logic [W-1:0] posted_q, queued_q;
  logic         has_queue, reload;

  // Next posted word: a read promotes the queue, else it takes fresh events.
  function automatic logic [W-1:0] next_posted(input logic [W-1:0] p,
      input logic [W-1:0] q, input logic [W-1:0] e, input logic rd);
    if (rd)           return (q != '0) ? q : e;
    else if (p == '0) return e;
    else              return p;
  endfunction

  // Next queued word: events stack behind a posted word and merge by OR.
  function automatic logic [W-1:0] next_queued(input logic [W-1:0] p,
      input logic [W-1:0] q, input logic [W-1:0] e, input logic rd);
    if (rd)           return (q != '0) ? e : '0;
    else if (p == '0) return '0;
    else              return q | e;
  endfunction

  assign has_queue = (queued_q != '0);
  assign reload    = rd_clr && has_queue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      posted_q <= '0;
      queued_q <= '0;
    end else begin
      posted_q <= next_posted(posted_q, queued_q, ev, rd_clr);
      queued_q <= next_queued(posted_q, queued_q, ev, rd_clr);
    end
  end

  assign posted = posted_q;

  assert_post_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (posted_q == '0 && !rd_clr && ev != '0) |=> (posted_q == $past(ev)));

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !has_queue && ev == '0) |=> (posted_q == '0));

  assert_queue_behind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    has_queue |-> (posted_q != '0));

  assert_read_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (posted_q == $past(queued_q)));
endmodule

// File: rtl/isc_classify.sv
`timescale 1ns/1ps
module isc_classify #(
  parameter int               DEV_W = 7,
  parameter int               BEV_W = 16,
  parameter logic [BEV_W-1:0] FATAL = '0
)(
  input  logic [DEV_W-1:0] dma_posted,
  input  logic [DEV_W-1:0] dma_en,
  input  logic [BEV_W-1:0] bus_posted,
  input  logic [BEV_W-1:0] bus_en,
  output logic             irq,
  output logic             halt,
  output logic             dma_pend,
  output logic             bus_pend
);
  // A bus bit halts when its class is fatal or its enable promotes it.
  function automatic logic bus_halts(input logic [BEV_W-1:0] p,
      input logic [BEV_W-1:0] en);
    return |(p & (en | FATAL));
  endfunction

  function automatic logic any_enabled(input logic [DEV_W-1:0] dp,
      input logic [DEV_W-1:0] de, input logic [BEV_W-1:0] bp,
      input logic [BEV_W-1:0] be);
    return (|(dp & de)) | (|(bp & be));
  endfunction

  assign dma_pend = |dma_posted;
  assign bus_pend = |bus_posted;
  assign irq      = any_enabled(dma_posted, dma_en, bus_posted, bus_en);
  assign halt     = dma_pend | bus_halts(bus_posted, bus_en);
endmodule

// File: rtl/isc_fifo_ctl.sv
`timescale 1ns/1ps
module isc_fifo_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_clr_req,
  input  logic dma_flush_req,
  input  logic bus_clr_req,
  output logic dma_clr,
  output logic dma_flush,
  output logic bus_clr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_clr   <= 1'b0;
      dma_flush <= 1'b0;
      bus_clr   <= 1'b0;
    end else begin
      dma_clr   <= dma_clr_req;
      dma_flush <= dma_flush_req;
      bus_clr   <= bus_clr_req;
    end
  end

  assert_dclr_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_clr |-> $past(dma_clr_req));

  assert_flush_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_flush |-> $past(dma_flush_req));

  assert_bclr_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clr |-> $past(bus_clr_req));
endmodule

// File: rtl/intr_stack_ctrl.sv
`timescale 1ns/1ps
module intr_stack_ctrl #(
  parameter int                         DATA_W    = 8,
  parameter int                         BUS_REGS  = 2,
  parameter int                         ADDR_W    = 4,
  parameter logic [BUS_REGS*DATA_W-1:0] BUS_FATAL = 'h0003
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DATA_W-2:0]            dma_ev,
  input  logic [BUS_REGS*DATA_W-1:0]   bus_ev,
  input  logic                         dma_fifo_empty,
  input  logic                         bus_fifo_empty,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic                         reg_wr,
  input  logic [DATA_W-1:0]            reg_wdata,
  input  logic                         reg_rd,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         dma_fifo_clr,
  output logic                         dma_fifo_flush,
  output logic                         bus_fifo_clr,
  output logic                         irq,
  output logic                         halt
);
  import isc_pkg::*;

  localparam int DEV_W  = DATA_W - 1;
  localparam int BEV_W  = BUS_REGS * DATA_W;
  localparam int A_DST  = 0;
  localparam int A_DEN  = 1;
  localparam int A_BST  = 2;
  localparam int A_BEN  = A_BST + BUS_REGS;
  localparam int A_SUM  = A_BEN + BUS_REGS;
  localparam int A_DCTL = A_SUM + 1;
  localparam int A_BCTL = A_SUM + 2;

  function automatic logic adr_is(input logic [ADDR_W-1:0] a, input int n);
    return a == ADDR_W'(n);
  endfunction

  // Named internal events
  logic             rd_dma;
  logic [BUS_REGS-1:0] rd_bus;
  logic [DEV_W-1:0] dma_posted;
  logic [BEV_W-1:0] bus_posted;
  logic [DEV_W-1:0] dma_en_q;
  logic [BEV_W-1:0] bus_en_q;
  logic             fifo_empty_all;
  logic             dma_pend, bus_pend;
  logic             dma_clr_req, dma_flush_req, bus_clr_req;
  summary_t         summary;

  assign rd_dma         = reg_rd && adr_is(reg_addr, A_DST);
  assign fifo_empty_all = dma_fifo_empty && bus_fifo_empty;

  // DMA-class status with its one-deep queue
  isc_stack #(.W(DEV_W)) u_dma_stack (
    .clk(clk), .rst_n(rst_n), .ev(dma_ev), .rd_clr(rd_dma),
    .posted(dma_posted)
  );

  // Bus-class status bank
  for (genvar g = 0; g < BUS_REGS; g++) begin : g_bus
    assign rd_bus[g] = reg_rd && adr_is(reg_addr, A_BST + g);
    isc_stack #(.W(DATA_W)) u_bus_stack (
      .clk(clk), .rst_n(rst_n), .ev(bus_ev[g*DATA_W +: DATA_W]),
      .rd_clr(rd_bus[g]), .posted(bus_posted[g*DATA_W +: DATA_W])
    );
  end

  // Enable registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en_q <= '0;
      bus_en_q <= '0;
    end else if (reg_wr) begin
      if (adr_is(reg_addr, A_DEN)) dma_en_q <= reg_wdata[DEV_W-1:0];
      for (int i = 0; i < BUS_REGS; i++)
        if (adr_is(reg_addr, A_BEN + i)) bus_en_q[i*DATA_W +: DATA_W] <= reg_wdata;
    end
  end

  isc_classify #(.DEV_W(DEV_W), .BEV_W(BEV_W), .FATAL(BUS_FATAL)) u_classify (
    .dma_posted(dma_posted), .dma_en(dma_en_q),
    .bus_posted(bus_posted), .bus_en(bus_en_q),
    .irq(irq), .halt(halt), .dma_pend(dma_pend), .bus_pend(bus_pend)
  );

  // FIFO control strobes
  assign dma_clr_req   = reg_wr && adr_is(reg_addr, A_DCTL) && reg_wdata[DCTL_CLR_BIT];
  assign dma_flush_req = reg_wr && adr_is(reg_addr, A_DCTL) && reg_wdata[DCTL_FLUSH_BIT];
  assign bus_clr_req   = reg_wr && adr_is(reg_addr, A_BCTL) && reg_wdata[BCTL_CLR_BIT];

  isc_fifo_ctl u_fifo_ctl (
    .clk(clk), .rst_n(rst_n),
    .dma_clr_req(dma_clr_req), .dma_flush_req(dma_flush_req),
    .bus_clr_req(bus_clr_req),
    .dma_clr(dma_fifo_clr), .dma_flush(dma_fifo_flush), .bus_clr(bus_fifo_clr)
  );

  // Read mux
  always_comb begin
    summary.irq      = irq;
    summary.halt     = halt;
    summary.bus_pend = bus_pend;
    summary.dma_pend = dma_pend;
    reg_rdata = '0;
    if (reg_rd) begin
      if (adr_is(reg_addr, A_DST)) reg_rdata = {fifo_empty_all, dma_posted};
      if (adr_is(reg_addr, A_DEN)) reg_rdata = {1'b0, dma_en_q};
      if (adr_is(reg_addr, A_SUM)) reg_rdata = DATA_W'(pack_summary(summary));
      for (int i = 0; i < BUS_REGS; i++) begin
        if (adr_is(reg_addr, A_BST + i)) reg_rdata = bus_posted[i*DATA_W +: DATA_W];
        if (adr_is(reg_addr, A_BEN + i)) reg_rdata = bus_en_q[i*DATA_W +: DATA_W];
      end
    end
  end

  assert_dma_halts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_posted != '0) |-> halt);

  assert_irq_implies_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> halt);

  assert_fifo_bit_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_dma |-> (reg_rdata[DATA_W-1] == (dma_fifo_empty && bus_fifo_empty)));

  assert_no_strobe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_wr) |-> !(dma_fifo_clr || dma_fifo_flush || bus_fifo_clr));
endmodule

// File: tb/sim_intr_stack_ctrl.sv
`timescale 1ns/1ps
module sim_intr_stack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  dma_ev = '0;
  logic [15:0] bus_ev = '0;
  logic        dma_fifo_empty = 1'b0, bus_fifo_empty = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dma_fifo_clr, dma_fifo_flush, bus_fifo_clr, irq, halt;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_stack_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dma_ev(dma_ev), .bus_ev(bus_ev),
    .dma_fifo_empty(dma_fifo_empty), .bus_fifo_empty(bus_fifo_empty),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .dma_fifo_clr(dma_fifo_clr), .dma_fifo_flush(dma_fifo_flush),
    .bus_fifo_clr(bus_fifo_clr), .irq(irq), .halt(halt)
  );

  typedef struct packed {
    logic [6:0]  den;
    logic [15:0] ben;
    logic [6:0]  dev;
    logic [15:0] bev;
    logic        x_irq;
    logic        x_halt;
  } vec_t;

  // Bus bits 0 and 1 are always fatal.
  localparam vec_t VECS [9] = '{
    '{7'h00, 16'h0000, 7'h01, 16'h0000, 1'b0, 1'b1},
    '{7'h01, 16'h0000, 7'h01, 16'h0000, 1'b1, 1'b1},
    '{7'h00, 16'h0000, 7'h00, 16'h0004, 1'b0, 1'b0},
    '{7'h00, 16'h0004, 7'h00, 16'h0004, 1'b1, 1'b1},
    '{7'h00, 16'h0000, 7'h00, 16'h0001, 1'b0, 1'b1},
    '{7'h00, 16'h0100, 7'h00, 16'h0100, 1'b1, 1'b1},
    '{7'h00, 16'h0000, 7'h00, 16'h0200, 1'b0, 1'b0},
    '{7'h3f, 16'h0000, 7'h40, 16'h0000, 1'b0, 1'b1},
    '{7'h7f, 16'hffff, 7'h55, 16'ha5a5, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] de, input logic [15:0] be);
    dma_ev = de; bus_ev = be;
    @(negedge clk);
    dma_ev = '0; bus_ev = '0;
  endtask

  task automatic strobes(input string req, input logic [2:0] exp);
    chk(req, "strobes", {dma_fifo_clr, dma_fifo_flush, bus_fifo_clr}, exp);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10", "irq after reset", irq, 0);
    chk("R10", "halt after reset", halt, 0);
    strobes("R10", 3'b000);
    rd(4'd0, d); chk("R10", "dma status reset", d, 8'h00);
    rd(4'd1, d); chk("R10", "dma enable reset", d, 8'h00);
    rd(4'd4, d); chk("R10", "bus enable reset", d, 8'h00);
    rd(4'd6, d); chk("R11", "summary reset", d, 8'h00);

    // Table walk: R1 R2 R6 R7 R8 R9 R11
    foreach (VECS[i]) begin
      wr(4'd1, {1'b0, VECS[i].den});
      wr(4'd4, VECS[i].ben[7:0]);
      wr(4'd5, VECS[i].ben[15:8]);
      pulse(VECS[i].dev, VECS[i].bev);
      chk("R9", $sformatf("irq vec%0d", i), irq, VECS[i].x_irq);
      chk("R8", $sformatf("halt vec%0d", i), halt, VECS[i].x_halt);
      rd(4'd6, d);
      chk("R11", $sformatf("summary vec%0d", i), d,
          {4'h0, VECS[i].x_irq, VECS[i].x_halt, |VECS[i].bev, |VECS[i].dev});
      rd(4'd0, d); chk("R1", $sformatf("dma status vec%0d", i), d, {1'b0, VECS[i].dev});
      rd(4'd2, d); chk("R1", $sformatf("bus0 status vec%0d", i), d, VECS[i].bev[7:0]);
      rd(4'd3, d); chk("R6", $sformatf("bus1 status vec%0d", i), d, VECS[i].bev[15:8]);
      chk("R2", $sformatf("irq cleared vec%0d", i), irq, 0);
      chk("R2", $sformatf("halt cleared vec%0d", i), halt, 0);
      rd(4'd0, d); chk("R2", $sformatf("dma reread vec%0d", i), d, 8'h00);
    end

    // R10: enables read back; status writes ignored
    wr(4'd1, 8'h00); wr(4'd4, 8'h00); wr(4'd5, 8'h5a);
    rd(4'd5, d); chk("R10", "enable readback", d, 8'h5a);
    wr(4'd5, 8'h00);
    wr(4'd0, 8'h7f); rd(4'd0, d); chk("R10", "status write ignored", d, 8'h00);
    wr(4'd6, 8'hff); rd(4'd6, d); chk("R10", "summary write ignored", d, 8'h00);

    // R3: stacking, OR into the queue, reload on read
    pulse(7'h01, 16'h0); pulse(7'h02, 16'h0); pulse(7'h04, 16'h0);
    rd(4'd0, d); chk("R3", "first posted word", d, 8'h01);
    rd(4'd6, d); chk("R3", "pending after reload", d[0], 1);
    chk("R7", "halt held by reloaded word", halt, 1);
    rd(4'd0, d); chk("R3", "queued ORed word", d, 8'h06);
    rd(4'd0, d); chk("R2", "drained", d, 8'h00);
    rd(4'd6, d); chk("R2", "pending cleared", d, 8'h00);
    // read with empty queue loads same-cycle events
    pulse(7'h08, 16'h0);
    reg_addr = 4'd0; reg_rd = 1'b1; dma_ev = 7'h10;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; dma_ev = '0;
    chk("R3", "read during event", d, 8'h08);
    rd(4'd0, d); chk("R3", "same-cycle event loaded", d, 8'h10);
    rd(4'd0, d); chk("R3", "empty after", d, 8'h00);
    // bus queue
    pulse(7'h0, 16'h0010); pulse(7'h0, 16'h0020);
    rd(4'd2, d); chk("R3", "bus first word", d, 8'h10);
    rd(4'd2, d); chk("R3", "bus queued word", d, 8'h20);

    // R4: FIFO-empty bit
    dma_fifo_empty = 1'b1; bus_fifo_empty = 1'b1;
    @(negedge clk);
    rd(4'd0, d); chk("R4", "fifo bit set", d, 8'h80);
    rd(4'd0, d); chk("R4", "fifo bit not cleared", d, 8'h80);
    chk("R4", "fifo bit no irq", irq, 0);
    chk("R4", "fifo bit no halt", halt, 0);
    bus_fifo_empty = 1'b0;
    rd(4'd0, d); chk("R4", "fifo bit needs both", d, 8'h00);
    dma_fifo_empty = 1'b0;

    // R5: strobes
    pulse(7'h7f, 16'hffff);
    strobes("R5", 3'b000);
    @(negedge clk); strobes("R5", 3'b000);
    rd(4'd0, d); rd(4'd2, d); rd(4'd3, d);
    wr(4'd7, 8'h04); strobes("R5", 3'b100);
    @(negedge clk);  strobes("R5", 3'b000);
    wr(4'd7, 8'h08); strobes("R5", 3'b010);
    @(negedge clk);  strobes("R5", 3'b000);
    wr(4'd8, 8'h02); strobes("R5", 3'b001);
    @(negedge clk);  strobes("R5", 3'b000);
    wr(4'd7, 8'h02); strobes("R5", 3'b000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule